// File: doc/BRIEF.md
# Statically Scheduled Tile Crossbar Interface

This block is the network interface of one tile in a mesh of heterogeneous cores. A five-way crossbar takes words from the north, south, east and west neighbours and from the local core. It drives the four neighbour outputs and a local output toward the core. No packet headers and no arbitration are used. A program counter steps through a small instruction memory, and the word it points at sets the routing for that clock cycle. Every transfer therefore follows a schedule fixed before run time. One source may feed several outputs in the same cycle.

The schedule is loaded through a configuration write port while the scheduler is disabled. Once it is enabled, the program counter runs through the entries and wraps back to zero, so the schedule repeats. Words routed to the local output go into a small FIFO coreport, which the core drains with a pop strobe. A scheduled word that arrives while that FIFO is full is lost and raises a sticky overflow flag.

Top module: `tile_xbar_if`

## Requirements
- R1: After rst_ni is released, all four neighbour valid outputs are low, core_valid_o is low and ovf_o is low.
- R2: A configuration write (cfg_we_i high at a clock edge) stores cfg_data_i at cfg_addr_i only while en_i is low. While en_i is high the write is ignored and the routing in use does not change.
- R3: At any edge where en_i is low, the program counter returns to entry 0 and all neighbour valid outputs go low at that edge.
- R4: Instruction bits [3k+2:3k] hold the source select of output k, with outputs ordered north=0, south=1, east=2, west=3, local=4. Codes 0 to 4 name the source in the same order, and the local source is the core's outgoing word on input index 4. With en_i high, a neighbour output whose select is 0 to 4 registers the data and valid of that source at the edge, so they are visible one cycle later.
- R5: Select codes 5, 6 and 7 are idle. A neighbour output with an idle select drives its valid low after the edge, and the local output pushes nothing.
- R6: One source may be selected by several outputs in the same instruction. Each of those outputs then carries that source's word.
- R7: Instruction bits [18:15] hold a last-index field. After it executes entry p, the program counter moves to p+1, or to 0 if that entry's last-index field equals p. The schedule therefore repeats with a programmable length of 1 to 16 entries.
- R8: A valid word routed to the local output is pushed into a 4-entry FIFO. core_valid_o is high while the FIFO holds a word, and core_data_o shows the oldest word. A pop (core_pop_i high at an edge) removes that word, so words leave in arrival order.
- R9: A push into a FIFO that is full at the start of the cycle drops the word and sets ovf_o. ovf_o stays set while en_i is high, and it clears at an edge where en_i is low.
- R10: A pop while the FIFO is empty is ignored: core_valid_o stays low and later words are unaffected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| en_i | input | 1 | Scheduler run enable; low holds the program counter at 0 and opens configuration |
| cfg_we_i | input | 1 | Instruction memory write strobe |
| cfg_addr_i | input | AW (4) | Instruction memory write address |
| cfg_data_i | input | IW (19) | Instruction word to write |
| nw_data_i | input | 5*DW (80) | Source data, slices ordered north, south, east, west, local |
| nw_valid_i | input | 5 | Source valid flags, same order |
| nw_data_o | output | 4*DW (64) | Registered neighbour output data, slices ordered north, south, east, west |
| nw_valid_o | output | 4 | Registered neighbour output valid flags |
| core_pop_i | input | 1 | Core removes the oldest coreport word |
| core_data_o | output | DW (16) | Oldest coreport word |
| core_valid_o | output | 1 | Coreport holds at least one word |
| ovf_o | output | 1 | Sticky coreport overflow flag |

## Verification
The assertions assume that rst_ni is asserted before the first edge. They also assume that en_i changes only between edges, so the program counter rules apply cycle by cycle. They assume nothing about the data, and any select code, valid pattern or pop timing is legal. The stimulus writes the instruction memory only with en_i low, except for the deliberate write under R2. It drives inputs and pops on the falling edge, and after every test it drains the coreport with en_i low, so each test starts from a known schedule and an empty FIFO.

// File: rtl/tile_xbar_pkg.sv
package tile_xbar_pkg;
  localparam int NDIR  = 5;  // north, south, east, west, local
  localparam int NNET  = 4;  // neighbour outputs
  localparam int SEL_W = 3;
  localparam int LOCAL = 4;
  localparam logic [SEL_W-1:0] SEL_IDLE = '1;
endpackage

// File: rtl/xbar_sched.sv
module xbar_sched
  import tile_xbar_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int AW = $clog2(DEPTH),
  localparam int IW = NDIR*SEL_W + AW
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [IW-1:0] wdata_i,
  output logic [IW-1:0] instr_o,
  output logic [AW-1:0] pc_o,
  output logic [AW-1:0] last_o
);
  logic [IW-1:0] mem_q [DEPTH];
  logic [AW-1:0] pc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= {{AW{1'b0}}, {NDIR{SEL_IDLE}}};
    end else if (we_i && !en_i) begin
      mem_q[waddr_i] <= wdata_i;
    end
  end

  assign instr_o = mem_q[pc_q];
  assign last_o  = instr_o[NDIR*SEL_W +: AW];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              pc_q <= '0;
    else if (!en_i)           pc_q <= '0;
    else if (pc_q == last_o)  pc_q <= '0;
    else                      pc_q <= pc_q + 1'b1;
  end

  assign pc_o = pc_q;
endmodule

// File: rtl/xbar_mux.sv
module xbar_mux
  import tile_xbar_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic [SEL_W-1:0]   sel_i,
  input  logic [NDIR*DW-1:0] data_i,
  input  logic [NDIR-1:0]    valid_i,
  output logic [DW-1:0]      data_o,
  output logic               valid_o
);
  always_comb begin
    data_o  = '0;
    valid_o = 1'b0;
    if (int'(sel_i) < NDIR) begin
      data_o  = data_i[int'(sel_i)*DW +: DW];
      valid_o = valid_i[sel_i];
    end
  end
endmodule

// File: rtl/core_fifo.sv
module core_fifo #(
  parameter int DW    = 16,
  parameter int DEPTH = 4,
  localparam int PW = $clog2(DEPTH),
  localparam int CW = PW + 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  logic [DW-1:0] data_i,
  input  logic          pop_i,
  output logic [DW-1:0] data_o,
  output logic          valid_o,
  output logic          full_o
);
  logic [DW-1:0] buf_q [DEPTH];
  logic [PW-1:0] rd_q, wr_q;
  logic [CW-1:0] cnt_q;
  logic          push_ok, pop_ok;

  assign full_o  = (cnt_q == CW'(DEPTH));
  assign valid_o = (cnt_q != '0);
  assign push_ok = push_i && !full_o;
  assign pop_ok  = pop_i && valid_o;
  assign data_o  = buf_q[rd_q];

  always_ff @(posedge clk_i) begin
    if (push_ok) buf_q[wr_q] <= data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_q  <= '0;
      wr_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (push_ok) wr_q <= (wr_q == PW'(DEPTH-1)) ? '0 : wr_q + 1'b1;
      if (pop_ok)  rd_q <= (rd_q == PW'(DEPTH-1)) ? '0 : rd_q + 1'b1;
      cnt_q <= cnt_q + CW'(push_ok) - CW'(pop_ok);
    end
  end
endmodule

// File: rtl/tile_xbar_if.sv
module tile_xbar_if
  import tile_xbar_pkg::*;
#(
  parameter int DW         = 16,
  parameter int IMEM_DEPTH = 16,
  parameter int FIFO_DEPTH = 4,
  localparam int AW = $clog2(IMEM_DEPTH),
  localparam int IW = NDIR*SEL_W + AW
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               en_i,
  input  logic               cfg_we_i,
  input  logic [AW-1:0]      cfg_addr_i,
  input  logic [IW-1:0]      cfg_data_i,
  input  logic [NDIR*DW-1:0] nw_data_i,
  input  logic [NDIR-1:0]    nw_valid_i,
  output logic [NNET*DW-1:0] nw_data_o,
  output logic [NNET-1:0]    nw_valid_o,
  input  logic               core_pop_i,
  output logic [DW-1:0]      core_data_o,
  output logic               core_valid_o,
  output logic               ovf_o
);
  logic [IW-1:0]      instr;
  logic [AW-1:0]      pc, cur_last;
  logic [NDIR*DW-1:0] mux_data;
  logic [NDIR-1:0]    mux_valid;
  logic               loc_push, fifo_full, ovf_q;

  xbar_sched #(.DEPTH(IMEM_DEPTH)) i_sched (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (en_i),
    .we_i   (cfg_we_i),
    .waddr_i(cfg_addr_i),
    .wdata_i(cfg_data_i),
    .instr_o(instr),
    .pc_o   (pc),
    .last_o (cur_last)
  );

  for (genvar k = 0; k < NDIR; k++) begin : g_mux
    xbar_mux #(.DW(DW)) i_mux (
      .sel_i  (instr[k*SEL_W +: SEL_W]),
      .data_i (nw_data_i),
      .valid_i(nw_valid_i),
      .data_o (mux_data[k*DW +: DW]),
      .valid_o(mux_valid[k])
    );
  end

  for (genvar k = 0; k < NNET; k++) begin : g_out
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        nw_data_o[k*DW +: DW] <= '0;
        nw_valid_o[k]         <= 1'b0;
      end else if (!en_i) begin
        nw_valid_o[k]         <= 1'b0;
      end else begin
        nw_data_o[k*DW +: DW] <= mux_data[k*DW +: DW];
        nw_valid_o[k]         <= mux_valid[k];
      end
    end
  end

  assign loc_push = en_i && mux_valid[LOCAL];

  core_fifo #(.DW(DW), .DEPTH(FIFO_DEPTH)) i_coreport (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .push_i (loc_push),
    .data_i (mux_data[LOCAL*DW +: DW]),
    .pop_i  (core_pop_i),
    .data_o (core_data_o),
    .valid_o(core_valid_o),
    .full_o (fifo_full)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    ovf_q <= 1'b0;
    else if (!en_i)                 ovf_q <= 1'b0;
    else if (loc_push && fifo_full) ovf_q <= 1'b1;
  end

  assign ovf_o = ovf_q;
endmodule

// File: rtl/tile_xbar_chk.sv
module tile_xbar_chk #(
  parameter int AW = 4
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          en_i,
  input logic [AW-1:0] pc_i,
  input logic [AW-1:0] last_i,
  input logic [3:0]    nw_valid_i,
  input logic          core_valid_i,
  input logic          push_i,
  input logic          ovf_i
);
  assert_off_quiet_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> nw_valid_i == '0);

  assert_pc_home_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> pc_i == '0);

  assert_pc_step_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && pc_i != last_i |=> pc_i == AW'($past(pc_i) + 1'b1));

  assert_pc_wrap_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && pc_i == last_i |=> pc_i == '0);

  assert_valid_needs_run_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    nw_valid_i != '0 |-> $past(en_i));

  assert_ovf_sticky_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && ovf_i |=> ovf_i);

  assert_pop_empty_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !core_valid_i && !push_i |=> !core_valid_i);
endmodule

bind tile_xbar_if tile_xbar_chk #(.AW(AW)) i_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .en_i        (en_i),
  .pc_i        (pc),
  .last_i      (cur_last),
  .nw_valid_i  (nw_valid_o),
  .core_valid_i(core_valid_o),
  .push_i      (loc_push),
  .ovf_i       (ovf_o)
);

// File: tb/test_tile_xbar_if.sv
module test_tile_xbar_if;
  import tile_xbar_pkg::*;
  localparam int DW = 16, ID = 16, FD = 4, AW = 4, IW = 19;

  logic clk = 1'b0, rst_n = 1'b0, en = 1'b0, cfg_we = 1'b0, pop = 1'b0;
  logic [AW-1:0]      cfg_addr = '0;
  logic [IW-1:0]      cfg_data = '0;
  logic [NDIR*DW-1:0] in_data = '0;
  logic [NDIR-1:0]    in_valid = '0;
  logic [NNET*DW-1:0] out_data;
  logic [NNET-1:0]    out_valid;
  logic [DW-1:0]      core_data;
  logic               core_valid, ovf;

  always #5 clk = ~clk;

  tile_xbar_if i_tile_xbar_if (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .cfg_we_i(cfg_we),
    .cfg_addr_i(cfg_addr), .cfg_data_i(cfg_data),
    .nw_data_i(in_data), .nw_valid_i(in_valid),
    .nw_data_o(out_data), .nw_valid_o(out_valid),
    .core_pop_i(pop), .core_data_o(core_data),
    .core_valid_o(core_valid), .ovf_o(ovf)
  );

  int errors = 0, checks = 0, cyc = 0;
  logic [IW-1:0] mem_m [ID];
  int pc_m = 0, cnt_m = 0;
  logic [DW-1:0] q_m [FD];
  bit ovf_m = 1'b0;
  string tag_g = "R4";

  function automatic logic [IW-1:0] mk(int last, int sn, int ss, int se, int sw, int sl);
    return {AW'(last), 3'(sl), 3'(sw), 3'(se), 3'(ss), 3'(sn)};
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic cfg(int a, logic [IW-1:0] w);
    cfg_we = 1'b1; cfg_addr = AW'(a); cfg_data = w;
    @(posedge clk); @(negedge clk);
    cfg_we = 1'b0;
    if (!en) mem_m[a] = w;  // R2: writes count only when disabled
  endtask

  task automatic q_pop();
    for (int k = 0; k < FD-1; k++) q_m[k] = q_m[k+1];
    cnt_m--;
  endtask

  task automatic step(logic [NDIR-1:0] vm, bit p);
    logic [DW-1:0] d [NDIR];
    logic [NNET-1:0] ev;
    logic [DW-1:0] ed [NNET];
    string vt [NNET];
    logic [IW-1:0] w;
    bit pop_empty, full_pre;
    int sel;
    ev = '0;
    for (int i = 0; i < NDIR; i++) begin
      d[i] = DW'(cyc*37 + i*11 + 5);
      in_data[i*DW +: DW] = d[i];
    end
    for (int o = 0; o < NNET; o++) begin ed[o] = '0; vt[o] = "R3"; end
    in_valid = vm;
    pop = p;
    pop_empty = p && (cnt_m == 0);
    if (en) begin
      w = mem_m[pc_m];
      for (int o = 0; o < NNET; o++) begin
        sel = int'(w[3*o +: 3]);
        if (sel < NDIR) begin ev[o] = vm[sel]; ed[o] = d[sel]; vt[o] = tag_g; end
        else vt[o] = "R5";
      end
      full_pre = (cnt_m == FD);
      if (p && cnt_m > 0) q_pop();
      sel = int'(w[12 +: 3]);
      if (sel < NDIR && vm[sel]) begin
        if (full_pre) ovf_m = 1'b1;
        else begin q_m[cnt_m] = d[sel]; cnt_m++; end
      end
      pc_m = (pc_m == int'(w[15 +: AW])) ? 0 : pc_m + 1;
    end else begin
      if (p && cnt_m > 0) q_pop();
      ovf_m = 1'b0;
      pc_m = 0;
    end
    @(posedge clk); @(negedge clk);
    cyc++;
    pop = 1'b0;
    for (int o = 0; o < NNET; o++) begin
      chk(vt[o], 32'(out_valid[o]), 32'(ev[o]));
      if (ev[o]) chk(vt[o], 32'(out_data[o*DW +: DW]), 32'(ed[o]));
    end
    chk(pop_empty ? "R10" : "R8", 32'(core_valid), 32'(cnt_m > 0));
    if (cnt_m > 0) chk("R8", 32'(core_data), 32'(q_m[0]));
    chk("R9", 32'(ovf), 32'(ovf_m));
  endtask

  task automatic drain();
    en = 1'b0;
    for (int n = 0; n < 8 && cnt_m > 0; n++) step('0, 1'b1);
    step('0, 1'b0);
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #2000000;
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    finish_run();
  end

  initial begin
    for (int i = 0; i < ID; i++) mem_m[i] = mk(0, 7, 7, 7, 7, 7);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", 32'(out_valid), 32'h0);
    chk("R1", 32'(core_valid), 32'h0);
    chk("R1", 32'(ovf), 32'h0);

    // R4/R5: every select code on every output, single-entry schedule
    tag_g = "R4";
    for (int s = 0; s < 8; s++) begin
      for (int o = 0; o < NDIR; o++) begin
        int sv [NDIR];
        for (int k = 0; k < NDIR; k++) sv[k] = (k == o) ? s : 7;
        cfg(0, mk(0, sv[0], sv[1], sv[2], sv[3], sv[4]));
        en = 1'b1;
        step(5'b11111, 1'b0);
        step(5'b10101, 1'b0);
        step(5'b01010, 1'b0);
        drain();
      end
    end

    // R6: north broadcast to south, east, west and local
    tag_g = "R6";
    cfg(0, mk(0, 7, 0, 0, 0, 0));
    en = 1'b1;
    step(5'b11111, 1'b0);
    step(5'b11110, 1'b0);
    step(5'b00001, 1'b1);
    drain();

    // R7: five-entry schedule, then full sixteen-entry schedule
    tag_g = "R7";
    for (int a = 0; a < 5; a++)
      cfg(a, mk((a == 4) ? 4 : 15, a % 8, (a+1) % 8, (a+2) % 8, (a+3) % 8, (a+4) % 8));
    en = 1'b1;
    for (int k = 0; k < 13; k++) step(5'(k*13 + 7), (k % 3) == 0);
    drain();
    for (int a = 0; a < ID; a++)
      cfg(a, mk(15, (a*3) % 8, (a+5) % 8, (a*7+1) % 8, (a+2) % 8, (a*5+3) % 8));
    en = 1'b1;
    for (int k = 0; k < 40; k++) step(5'(k*7 + 3), (k % 2) == 0);
    drain();

    // R9/R10: overflow into full coreport, sticky while running, empty pops
    tag_g = "R4";
    for (int a = 0; a < ID; a++) cfg(a, mk(0, 7, 7, 7, 7, 0));
    en = 1'b1;
    for (int k = 0; k < 6; k++) step(5'b11111, 1'b0);
    for (int k = 0; k < 6; k++) step(5'b11110, 1'b1);
    en = 1'b0;
    step('0, 1'b1);
    step('0, 1'b0);

    // R2: a write while running is ignored
    tag_g = "R2";
    cfg(0, mk(0, 0, 7, 7, 7, 7));
    en = 1'b1;
    cfg(0, mk(0, 1, 1, 1, 1, 1));
    for (int k = 0; k < 3; k++) step(5'b11111, 1'b0);
    drain();

    finish_run();
  end
endmodule